// File: doc/BRIEF.md
# Multi-width RGB pixel capture

This block turns the traffic of a parallel RGB video port into 18-bit pixels (6 bits each of red, green and blue) for a frame store. The port carries a dot clock, a data-enable line, active-low horizontal and vertical sync lines and an 18-bit data bus. The block runs on a faster system clock and samples the dot clock as a plain signal. It detects the programmed active dot-clock edge and takes the data, enable and sync levels present at that edge.

One bus can carry pixels in three ways. In the full-width mode each beat is one 18-bit pixel. In the 16-bit mode each beat is one 5-6-5 word spread over two pin groups, and the block widens it to 6-6-6. In the 6-bit mode three beats on the top six pins give red, green and blue in turn. Both the dot-clock edge and the enable level are programmable. Each finished pixel comes out with a one-cycle valid strobe. It also carries flags marking the first pixel after a vertical sync and the first pixel after a horizontal sync. Address generation and sync timing generation are handled elsewhere.

The dot clock must stay high for at least two system-clock periods and low for at least two. The bus, enable and sync lines must be stable when the active dot edge reaches the pins.

Top module: `rgb_pixel_capture`

## Requirements
- R1: After reset, and until the first pixel is complete, pix_valid, pix_sof and pix_sol are 0 and pix_data is 0.
- R2: With cfg_mode = 2'b00, each enabled beat gives one pixel equal to vid_data[17:0] (red in bits 17:12, green in 11:6, blue in 5:0).
- R3: With cfg_mode = 2'b01, each enabled beat forms w = {vid_data[17:10], vid_data[8:1]} and gives pixel {w[15:11], w[15], w[10:5], w[4:0], w[4]}. Bits 9 and 0 of the bus have no effect.
- R4: With cfg_mode = 2'b10, enabled beats take vid_data[17:12] as red, then green, then blue. The third beat gives pixel {red, green, blue}, and bits 11:0 of the bus have no effect.
- R5: cfg_mode = 2'b11 behaves exactly as cfg_mode = 2'b00.
- R6: A beat counts only if vid_en is at its active level: low when cfg_en_pol = 0, high when cfg_en_pol = 1. Other beats produce no pixel and do not advance the 6-bit beat sequence.
- R7: Beats are taken on the rising edge of vid_dot when cfg_dot_pol = 0 and on the falling edge when cfg_dot_pol = 1. The opposite edge has no effect.
- R8: vid_hsync low at an active dot edge restarts the 6-bit sequence, discarding a partial pixel (a beat taken at that same edge, if enabled, is the red beat). The next pixel completed carries pix_sol = 1.
- R9: vid_vsync low at an active dot edge also restarts the 6-bit sequence, and the next pixel completed carries pix_sof = 1.
- R10: pix_valid is a single-cycle strobe that rises on the second system-clock edge after the completing active dot edge appears at the pins. pix_sof and pix_sol are only ever 1 while pix_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Bus mode: 00 full 18-bit, 01 16-bit 5-6-5, 10 6-bit three beats, 11 as 00 |
| cfg_dot_pol | input | 1 | 0: sample on rising dot edge, 1: on falling |
| cfg_en_pol | input | 1 | 0: enable active low, 1: active high |
| vid_dot | input | 1 | Video dot clock |
| vid_en | input | 1 | Video data enable |
| vid_hsync | input | 1 | Horizontal sync, active low |
| vid_vsync | input | 1 | Vertical sync, active low |
| vid_data | input | 18 | Video data bus |
| pix_valid | output | 1 | One-cycle strobe for a finished pixel |
| pix_data | output | 18 | Finished pixel, red in 17:12, green 11:6, blue 5:0 |
| pix_sof | output | 1 | Pixel is the first after a vertical sync |
| pix_sol | output | 1 | Pixel is the first after a horizontal sync |

## Verification
A beat counter that is off by one shows up at the ports as a pixel whose channels are rotated or hold stale data, at most three enabled beats after the fault. A sync flag that is lost or never cleared shows up as a missing or extra pix_sof or pix_sol on the very next pixel. A wrong edge or enable decode shows up as a surplus or missing pixel, which the scoreboard catches at once as an empty queue or as leftover items. Exact latency is checked on chosen beats so that an added or missing pipeline stage is visible at the second system-clock edge.

// File: rtl/rgbcap_pkg.sv
package rgbcap_pkg;

  localparam int CH_W   = 6;
  localparam int PIX_W  = 3 * CH_W;
  localparam int W16_W  = 16;
  localparam int BEATS6 = 3;
  localparam int BCNT_W = $clog2(BEATS6);

  typedef enum logic [1:0] {
    MODE_W18 = 2'b00,
    MODE_W16 = 2'b01,
    MODE_W6  = 2'b10,
    MODE_RSV = 2'b11
  } bus_mode_e;

  // The reserved code falls back to the full-width bus.
  function automatic bus_mode_e effective_mode(input logic [1:0] code);
    bus_mode_e m;
    case (code)
      2'b01:   m = MODE_W16;
      2'b10:   m = MODE_W6;
      default: m = MODE_W18;
    endcase
    return m;
  endfunction

  // Gather the two 8-pin groups of the 16-bit bus into one word.
  function automatic logic [W16_W-1:0] gather16(input logic [PIX_W-1:0] bus);
    return {bus[17:10], bus[8:1]};
  endfunction

  // Widen a 5-6-5 word to 6-6-6 by repeating the red and blue MSBs.
  function automatic logic [PIX_W-1:0] widen565(input logic [W16_W-1:0] w);
    logic [4:0] r5;
    logic [5:0] g6;
    logic [4:0] b5;
    r5 = w[15:11];
    g6 = w[10:5];
    b5 = w[4:0];
    return {r5, r5[4], g6, b5, b5[4]};
  endfunction

  // Channel carried on a 6-bit beat.
  function automatic logic [CH_W-1:0] narrow_lane(input logic [PIX_W-1:0] bus);
    return bus[PIX_W-1 -: CH_W];
  endfunction

endpackage

// File: rtl/rgbcap_sampler.sv
module rgbcap_sampler
  import rgbcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dot_pol,
  input  logic             en_pol,
  input  logic             vid_dot,
  input  logic             vid_en,
  input  logic             vid_hsync,
  input  logic             vid_vsync,
  input  logic [PIX_W-1:0] vid_data,
  output logic             samp_evt,
  output logic             samp_en,
  output logic             samp_hs_lo,
  output logic             samp_vs_lo,
  output logic [PIX_W-1:0] samp_data
);

  logic             dot_q, dot_qq;
  logic             en_q, hs_q, vs_q;
  logic [PIX_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= 1'b0;
      dot_qq <= 1'b0;
      en_q   <= 1'b0;
      hs_q   <= 1'b1;
      vs_q   <= 1'b1;
      data_q <= '0;
    end else begin
      dot_q  <= vid_dot;
      dot_qq <= dot_q;
      en_q   <= vid_en;
      hs_q   <= vid_hsync;
      vs_q   <= vid_vsync;
      data_q <= vid_data;
    end
  end

  // An active edge is a change whose new level is the inverse of the polarity bit.
  always_comb begin
    samp_evt   = (dot_q != dot_qq) && (dot_q == ~dot_pol);
    samp_en    = en_pol ? en_q : ~en_q;
    samp_hs_lo = ~hs_q;
    samp_vs_lo = ~vs_q;
    samp_data  = data_q;
  end

endmodule

// File: rtl/rgbcap_assembler.sv
module rgbcap_assembler
  import rgbcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_mode_e         mode,
  input  logic              samp_evt,
  input  logic              samp_en,
  input  logic              sync_lo,
  input  logic [PIX_W-1:0]  samp_data,
  output logic              pix_done,
  output logic [PIX_W-1:0]  pix_word,
  output logic [BCNT_W-1:0] beat_cnt
);

  localparam logic [BCNT_W-1:0] LAST_BEAT = BCNT_W'(BEATS6 - 1);

  logic [BCNT_W-1:0] cnt_q, cnt_base;
  logic [CH_W-1:0]   lane_q [BEATS6-1];
  logic              beat_ok;
  logic              narrow;

  assign narrow   = (mode == MODE_W6);
  assign beat_ok  = samp_evt && samp_en;
  assign cnt_base = (samp_evt && sync_lo) ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!narrow) begin
      cnt_q <= '0;
    end else if (beat_ok) begin
      cnt_q <= (cnt_base == LAST_BEAT) ? '0 : cnt_base + 1'b1;
    end else if (samp_evt && sync_lo) begin
      cnt_q <= '0;
    end
  end

  generate
    for (genvar i = 0; i < BEATS6 - 1; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q[i] <= '0;
        end else if (narrow && beat_ok && cnt_base == BCNT_W'(i)) begin
          lane_q[i] <= narrow_lane(samp_data);
        end
      end
    end
  endgenerate

  always_comb begin
    pix_done = beat_ok && (!narrow || cnt_base == LAST_BEAT);
    case (mode)
      MODE_W16: pix_word = widen565(gather16(samp_data));
      MODE_W6:  pix_word = {lane_q[0], lane_q[1], narrow_lane(samp_data)};
      default:  pix_word = samp_data;
    endcase
  end

  assign beat_cnt = cnt_q;

endmodule

// File: rtl/rgbcap_framer.sv
module rgbcap_framer
  import rgbcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_evt,
  input  logic             samp_hs_lo,
  input  logic             samp_vs_lo,
  input  logic             pix_done,
  input  logic [PIX_W-1:0] pix_word,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_sof,
  output logic             pix_sol
);

  logic frame_pend, line_pend;
  logic hs_now, vs_now;

  assign hs_now = samp_evt && samp_hs_lo;
  assign vs_now = samp_evt && samp_vs_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      pix_sof    <= 1'b0;
      pix_sol    <= 1'b0;
      frame_pend <= 1'b0;
      line_pend  <= 1'b0;
    end else if (pix_done) begin
      pix_valid  <= 1'b1;
      pix_data   <= pix_word;
      pix_sof    <= frame_pend || vs_now;
      pix_sol    <= line_pend || hs_now;
      frame_pend <= 1'b0;
      line_pend  <= 1'b0;
    end else begin
      pix_valid  <= 1'b0;
      pix_sof    <= 1'b0;
      pix_sol    <= 1'b0;
      frame_pend <= frame_pend || vs_now;
      line_pend  <= line_pend || hs_now;
    end
  end

endmodule

// File: rtl/rgb_pixel_capture.sv
module rgb_pixel_capture
  import rgbcap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_mode,
  input  logic        cfg_dot_pol,
  input  logic        cfg_en_pol,
  input  logic        vid_dot,
  input  logic        vid_en,
  input  logic        vid_hsync,
  input  logic        vid_vsync,
  input  logic [17:0] vid_data,
  output logic        pix_valid,
  output logic [17:0] pix_data,
  output logic        pix_sof,
  output logic        pix_sol
);

  bus_mode_e         mode;
  logic              samp_evt, samp_en, samp_hs_lo, samp_vs_lo;
  logic [PIX_W-1:0]  samp_data;
  logic              pix_done;
  logic [PIX_W-1:0]  pix_word;
  logic [BCNT_W-1:0] beat_cnt;
  logic              mode_narrow;

  assign mode        = effective_mode(cfg_mode);
  assign mode_narrow = (mode == MODE_W6);

  rgbcap_sampler u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot_pol    (cfg_dot_pol),
    .en_pol     (cfg_en_pol),
    .vid_dot    (vid_dot),
    .vid_en     (vid_en),
    .vid_hsync  (vid_hsync),
    .vid_vsync  (vid_vsync),
    .vid_data   (vid_data),
    .samp_evt   (samp_evt),
    .samp_en    (samp_en),
    .samp_hs_lo (samp_hs_lo),
    .samp_vs_lo (samp_vs_lo),
    .samp_data  (samp_data)
  );

  rgbcap_assembler u_assembler (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .samp_evt  (samp_evt),
    .samp_en   (samp_en),
    .sync_lo   (samp_hs_lo || samp_vs_lo),
    .samp_data (samp_data),
    .pix_done  (pix_done),
    .pix_word  (pix_word),
    .beat_cnt  (beat_cnt)
  );

  rgbcap_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_evt   (samp_evt),
    .samp_hs_lo (samp_hs_lo),
    .samp_vs_lo (samp_vs_lo),
    .pix_done   (pix_done),
    .pix_word   (pix_word),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .pix_sof    (pix_sof),
    .pix_sol    (pix_sol)
  );

endmodule

// File: rtl/rgbcap_checker.sv
module rgbcap_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_valid,
  input logic       pix_sof,
  input logic       pix_sol,
  input logic       samp_evt,
  input logic       mode_narrow,
  input logic [1:0] beat_cnt
);

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  assert_valid_after_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(samp_evt));

  assert_sof_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> pix_valid);

  assert_sol_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |-> pix_valid);

  assert_beat_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt <= 2'd2);

  assert_beat_idle_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_narrow |=> beat_cnt == 2'd0);

endmodule

bind rgb_pixel_capture rgbcap_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_valid   (pix_valid),
  .pix_sof     (pix_sof),
  .pix_sol     (pix_sol),
  .samp_evt    (samp_evt),
  .mode_narrow (mode_narrow),
  .beat_cnt    (beat_cnt)
);

// File: tb/tb_rgb_pixel_capture.sv
module tb_rgb_pixel_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        cfg_dot_pol = 1'b0;
  logic        cfg_en_pol = 1'b1;
  logic        vid_dot = 1'b0;
  logic        vid_en = 1'b0;
  logic        vid_hsync = 1'b1;
  logic        vid_vsync = 1'b1;
  logic [17:0] vid_data = '0;
  logic        pix_valid, pix_sof, pix_sol;
  logic [17:0] pix_data;

  always #10 clk = ~clk;

  rgb_pixel_capture dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dot_pol(cfg_dot_pol),
    .cfg_en_pol(cfg_en_pol), .vid_dot(vid_dot), .vid_en(vid_en),
    .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_data(vid_data),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof), .pix_sol(pix_sol)
  );

  typedef struct {
    logic [17:0] data;
    logic        sof;
    logic        sol;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  // bench model state
  int          m_beat = 0;
  logic [5:0]  m_red, m_grn;
  logic        m_sof = 0, m_sol = 0;

  function automatic logic [17:0] exp16(input logic [17:0] d);
    logic [15:0] w;
    w = {d[17:10], d[8:1]};
    return {w[15:11], w[15], w[10:5], w[4:0], w[4]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_mode = m;
    m_beat = 0;
  endtask

  task automatic push(input logic [17:0] d, input logic hs_lo, input logic vs_lo, input string req);
    exp_t e;
    e.data = d;
    e.sof = m_sof | vs_lo;
    e.sol = m_sol | hs_lo;
    e.req = req;
    exp_q.push_back(e);
    m_sof = 0;
    m_sol = 0;
  endtask

  // One dot period; lat=1 checks the exact output cycle (R10).
  task automatic beat(input logic [17:0] d, input logic act, input logic hs, input logic vs,
                      input string req, input bit lat = 0);
    logic hs_lo, vs_lo, pushed;
    hs_lo = ~hs;
    vs_lo = ~vs;
    pushed = 0;
    if (hs_lo || vs_lo) m_beat = 0;
    if (act) begin
      if (cfg_mode == 2'b10) begin
        case (m_beat)
          0: begin m_red = d[17:12]; m_beat = 1; end
          1: begin m_grn = d[17:12]; m_beat = 2; end
          default: begin push({m_red, m_grn, d[17:12]}, hs_lo, vs_lo, req); m_beat = 0; pushed = 1; end
        endcase
      end else if (cfg_mode == 2'b01) begin
        push(exp16(d), hs_lo, vs_lo, req); pushed = 1;
      end else begin
        push(d, hs_lo, vs_lo, req); pushed = 1;
      end
    end
    if (!pushed) begin
      m_sof = m_sof | vs_lo;
      m_sol = m_sol | hs_lo;
    end
    @(negedge clk);
    vid_dot = cfg_dot_pol;
    vid_data = d;
    vid_en = cfg_en_pol ? act : ~act;
    vid_hsync = hs;
    vid_vsync = vs;
    repeat (3) @(negedge clk);
    vid_dot = ~cfg_dot_pol;
    if (lat) begin
      @(negedge clk);
      check("R10 latency first edge", {31'd0, pix_valid}, 32'd0);
      @(negedge clk);
      check("R10 latency second edge", {31'd0, pix_valid}, 32'd1);
      @(negedge clk);
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R6 unexpected pixel actual=%0h expected=none", pix_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, {14'd0, pix_sof, pix_sol, pix_data}, {14'd0, e.sof, e.sol, e.data});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid after reset", {31'd0, pix_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid idle", {31'd0, pix_valid}, 32'd0);
    check("R1 data idle", {14'd0, pix_data}, 32'd0);
    check("R1 flags idle", {30'd0, pix_sof, pix_sol}, 32'd0);

    // R2 full width, syncs first with enable inactive
    set_mode(2'b00);
    beat(18'h00000, 0, 1, 0, "R9 sync only");
    beat(18'h00000, 0, 0, 1, "R8 sync only");
    beat(18'h3F03C, 1, 1, 1, "R2 first pixel sof sol");
    beat(18'h15A5A, 1, 1, 1, "R2 pixel", 1);
    beat(18'h2AAAA, 1, 1, 1, "R2 pixel");
    // R6 inactive beats give nothing
    beat(18'h3FFFF, 0, 1, 1, "R6 ignored");
    beat(18'h12345, 0, 1, 1, "R6 ignored");
    beat(18'h01234, 1, 1, 1, "R6 after ignored");

    // R5 reserved mode
    set_mode(2'b11);
    beat(18'h2DEAD, 1, 1, 1, "R5 reserved as full");
    beat(18'h1BEEF, 1, 0, 1, "R5 reserved with sol");

    // R3 16-bit
    set_mode(2'b01);
    beat(18'h3FDFE, 1, 1, 1, "R3 bits9 0 clear");
    beat(18'h00201, 1, 1, 1, "R3 only bits9 0");
    beat(18'h2B6D4, 1, 1, 1, "R3 mixed", 1);
    beat(18'h1FC00, 1, 1, 1, "R3 red/green msb");

    // R4 6-bit
    set_mode(2'b10);
    beat(18'h3F000, 1, 1, 1, "R4 red");
    beat(18'h15FFF, 1, 1, 1, "R4 green");
    beat(18'h2AABC, 1, 1, 1, "R4 blue");
    beat(18'h04111, 1, 1, 1, "R4 red");
    beat(18'h0BFFF, 0, 1, 1, "R6 skip in sequence");
    beat(18'h08222, 1, 1, 1, "R4 green");
    beat(18'h0C333, 1, 1, 1, "R4 blue after skip", 1);
    // R8 partial pixel discarded by hsync
    beat(18'h3C000, 1, 1, 1, "R8 discarded red");
    beat(18'h3D000, 1, 1, 1, "R8 discarded green");
    beat(18'h11000, 1, 0, 1, "R8 red at hsync");
    beat(18'h22000, 1, 1, 1, "R8 green");
    beat(18'h33000, 1, 1, 1, "R8 blue line start");
    // R9 vsync restarts sequence too
    beat(18'h3E000, 1, 1, 1, "R9 discarded red");
    beat(18'h05000, 0, 1, 0, "R9 vsync idle beat");
    beat(18'h06000, 1, 1, 1, "R9 red");
    beat(18'h07000, 1, 1, 1, "R9 green");
    beat(18'h08000, 1, 1, 1, "R9 blue frame start");

    // R6 enable active low
    set_mode(2'b00);
    @(negedge clk) cfg_en_pol = 1'b0;
    beat(18'h10101, 1, 1, 1, "R6 active low enable");
    beat(18'h20202, 0, 1, 1, "R6 inactive high");
    beat(18'h30303, 1, 1, 1, "R6 active low enable");

    // R7 falling edge sampling
    @(negedge clk) cfg_dot_pol = 1'b1;
    beat(18'h1ABCD, 1, 1, 1, "R7 falling edge", 1);
    beat(18'h2BCDE, 1, 1, 0, "R7 R9 vsync with pixel");
    beat(18'h0F0F0, 1, 1, 1, "R7 falling edge");
    @(negedge clk) cfg_dot_pol = 1'b0;
    beat(18'h3CDEF, 1, 1, 1, "R7 back to rising");

    repeat (10) @(negedge clk);
    check("R6 no pixels left over", exp_q.size(), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule